// File: doc/BRIEF.md
# E3 Frame Overhead Inserter

This block produces the serial outbound E3 line stream, one bit per clock enable, using a 1536-bit frame. Each frame starts with a 10-bit alignment word. An alarm bit and a national bit follow it, and the remaining positions carry payload drawn from an upstream source. The block requests a payload bit only when the next enabled clock will consume one, and it marks the first bit of every frame with a strobe.

For equipment testing, the alignment word can be corrupted on purpose. Two 5-bit XOR masks, one for each half of the word, are applied in every frame. The alarm and national bits each come either from a software-written service register or from an external pin. A 2-bit source field picks the origin of each bit. Configuration writes are staged and take effect only at a frame boundary.

Top module: `e3_ovh_inserter`

## Requirements
- R1: A frame is FRAME_BITS positions long. Positions 1 to 10 carry the alignment word 1111010000, sent leftmost bit first, and after position FRAME_BITS the next position is 1 again.
- R2: Position 11 carries the alarm bit and position 12 carries the national bit. Every other position carries the value on `pay_data`, in order.
- R3: Register address 0 holds the service bits: bit 1 is the alarm value and bit 0 is the national value. They reset to 1 and 0. A bit whose source field is 00 is sent with the value from this register.
- R4: Register address 1 holds the source fields: bits [1:0] for the alarm bit and bits [3:2] for the national bit. Any non-zero field sends the value of `a_ext` or `n_ext`. Those pins are sampled at the clock enable that emits position 1, and later changes within the frame have no effect on that frame.
- R5: Register address 2 holds the upper mask and address 3 holds the lower mask, each in bits [4:0]. Both reset to zero. Alignment position k is sent as the word bit XOR the mask bit, where mask bit 4 of the upper mask maps to position 1 and mask bit 4 of the lower mask maps to position 6.
- R6: A register write affects the stream from the first frame that starts after the last clock enable of the current frame. A write in the same cycle as that clock enable waits one more frame.
- R7: `frame_start` is high from the clock enable that emits position 1 until the next clock enable.
- R8: `pay_req` is high exactly when the next clock enable emits a payload position, and `pay_data` is sampled at that clock enable.
- R9: `line_bit`, `frame_start` and `pay_req` change only on cycles where `ce` is high, apart from reset.
- R10: A synchronous reset clears all three outputs and `rd_data`, loads the register defaults and makes position 1 the next position. Reading an address returns its stored fields in `rd_data` one cycle later, with the unused bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Bit-rate clock enable |
| pay_data | input | 1 | Payload bit, consumed when `pay_req` and `ce` are both high |
| pay_req | output | 1 | Next enabled clock consumes a payload bit |
| line_bit | output | 1 | Outbound serial line bit |
| frame_start | output | 1 | Current line bit is position 1 |
| a_ext | input | 1 | External alarm-bit value |
| n_ext | input | 1 | External national-bit value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with FRAME_BITS set to 48 instead of 1536. This makes a frame boundary occur every few dozen enabled clocks, so many frame wraps, staged register commits and pin samplings fit in a short run. With the short frame, the bench can also place writes on the last bit of a frame, change the external pins in the middle of a frame, reset in the middle of a frame and space out clock enables irregularly. All of these cases are covered against a position-by-position expected stream.

// File: rtl/e3_ovh_pkg.sv
package e3_ovh_pkg;
  localparam int REG_AW    = 2;
  localparam int REG_DW    = 8;
  localparam int MASK_W    = 5;
  localparam int FAW_W     = 2 * MASK_W;
  localparam int A_POS     = FAW_W;
  localparam int N_POS     = FAW_W + 1;
  localparam int PAY_FIRST = FAW_W + 2;
  localparam logic [FAW_W-1:0] FAW_WORD = 10'b1111010000;

  localparam logic [REG_AW-1:0] ADDR_SVC = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_SRC = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_MHI = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_MLO = 2'd3;
  localparam logic [1:0]        SRC_REG  = 2'b00;

  typedef struct packed {
    logic              a_val;
    logic              n_val;
    logic [1:0]        a_src;
    logic [1:0]        n_src;
    logic [MASK_W-1:0] m_hi;
    logic [MASK_W-1:0] m_lo;
  } ovh_cfg_t;

  localparam ovh_cfg_t CFG_RST = '{a_val: 1'b1, default: '0};
endpackage

// File: rtl/e3_ovh_regs.sv
module e3_ovh_regs
  import e3_ovh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  input  logic              commit,
  output ovh_cfg_t          cfg_act
);
  ovh_cfg_t          staged;
  logic [REG_DW-1:0] rd_nxt;

  // Software-visible staging copy
  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= CFG_RST;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_SVC: begin
          staged.a_val <= wr_data[1];
          staged.n_val <= wr_data[0];
        end
        ADDR_SRC: begin
          staged.a_src <= wr_data[1:0];
          staged.n_src <= wr_data[3:2];
        end
        ADDR_MHI: staged.m_hi <= wr_data[MASK_W-1:0];
        default:  staged.m_lo <= wr_data[MASK_W-1:0];
      endcase
    end
  end

  // Copy used by the frame, refreshed only at the frame boundary
  always_ff @(posedge clk) begin
    if (rst)         cfg_act <= CFG_RST;
    else if (commit) cfg_act <= staged;
  end

  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      ADDR_SVC: rd_nxt[1:0] = {staged.a_val, staged.n_val};
      ADDR_SRC: rd_nxt[3:0] = {staged.n_src, staged.a_src};
      ADDR_MHI: rd_nxt[MASK_W-1:0] = staged.m_hi;
      default:  rd_nxt[MASK_W-1:0] = staged.m_lo;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/e3_ovh_pos.sv
module e3_ovh_pos #(
  parameter int FRAME_BITS = 1536,
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] pos_nxt,
  output logic          at_last
);
  assign at_last = (pos == PW'(FRAME_BITS - 1));
  assign pos_nxt = at_last ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)     pos <= '0;
    else if (ce) pos <= pos_nxt;
  end
endmodule

// File: rtl/e3_ovh_mux.sv
module e3_ovh_mux
  import e3_ovh_pkg::*;
#(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] pos_nxt,
  input  ovh_cfg_t      cfg,
  input  logic          a_ext,
  input  logic          n_ext,
  input  logic          pay_data,
  output logic          line_bit,
  output logic          frame_start,
  output logic          pay_req
);
  localparam int FIW = $clog2(FAW_W);

  logic             a_pin_q, n_pin_q;
  logic [FAW_W-1:0] faw_tx;
  logic             a_bit, n_bit, bit_nxt, first_pos;

  assign first_pos = (pos == '0);

  // External service-bit pins are captured once per frame
  always_ff @(posedge clk) begin
    if (rst) begin
      a_pin_q <= 1'b0;
      n_pin_q <= 1'b0;
    end else if (ce && first_pos) begin
      a_pin_q <= a_ext;
      n_pin_q <= n_ext;
    end
  end

  always_comb begin
    faw_tx = FAW_WORD ^ {cfg.m_hi, cfg.m_lo};
    a_bit  = (cfg.a_src == SRC_REG) ? cfg.a_val : a_pin_q;
    n_bit  = (cfg.n_src == SRC_REG) ? cfg.n_val : n_pin_q;
    if (pos < PW'(FAW_W))
      bit_nxt = faw_tx[FIW'(FAW_W - 1) - pos[FIW-1:0]];
    else if (pos == PW'(A_POS))
      bit_nxt = a_bit;
    else if (pos == PW'(N_POS))
      bit_nxt = n_bit;
    else
      bit_nxt = pay_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit    <= 1'b0;
      frame_start <= 1'b0;
      pay_req     <= 1'b0;
    end else if (ce) begin
      line_bit    <= bit_nxt;
      frame_start <= first_pos;
      pay_req     <= (pos_nxt >= PW'(PAY_FIRST));
    end
  end
endmodule

// File: rtl/e3_ovh_inserter.sv
module e3_ovh_inserter
  import e3_ovh_pkg::*;
#(
  parameter int FRAME_BITS = 1536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              pay_data,
  output logic              pay_req,
  output logic              line_bit,
  output logic              frame_start,
  input  logic              a_ext,
  input  logic              n_ext,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data
);
  localparam int PW = $clog2(FRAME_BITS);

  logic [PW-1:0] pos, pos_nxt;
  logic          at_last;
  ovh_cfg_t      cfg_act;

  e3_ovh_pos #(.FRAME_BITS(FRAME_BITS), .PW(PW)) u_pos (
    .clk(clk), .rst(rst), .ce(ce),
    .pos(pos), .pos_nxt(pos_nxt), .at_last(at_last)
  );

  e3_ovh_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .commit(ce && at_last), .cfg_act(cfg_act)
  );

  e3_ovh_mux #(.PW(PW)) u_mux (
    .clk(clk), .rst(rst), .ce(ce),
    .pos(pos), .pos_nxt(pos_nxt), .cfg(cfg_act),
    .a_ext(a_ext), .n_ext(n_ext), .pay_data(pay_data),
    .line_bit(line_bit), .frame_start(frame_start), .pay_req(pay_req)
  );
endmodule

// File: rtl/e3_ovh_chk.sv
module e3_ovh_chk (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic line_bit,
  input logic frame_start,
  input logic pay_req
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!line_bit && !frame_start && !pay_req)); // R10

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(line_bit) && $stable(frame_start) && $stable(pay_req))); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    (frame_start && ce) |=> !frame_start); // R7

  AST_PAY_NOT_START: assert property (@(posedge clk) disable iff (rst)
    (pay_req && ce) |=> !frame_start); // R8

  AST_START_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !pay_req); // R1
endmodule

bind e3_ovh_inserter e3_ovh_chk u_chk (
  .clk(clk), .rst(rst), .ce(ce),
  .line_bit(line_bit), .frame_start(frame_start), .pay_req(pay_req)
);

// File: tb/tb_e3_ovh_inserter.sv
module tb_e3_ovh_inserter;
  import e3_ovh_pkg::*;
  localparam int FB = 48;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, pay_data = 1'b0;
  logic a_ext = 1'b0, n_ext = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic pay_req, line_bit, frame_start;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  e3_ovh_inserter #(.FRAME_BITS(FB)) dut (
    .clk(clk), .rst(rst), .ce(ce), .pay_data(pay_data), .pay_req(pay_req),
    .line_bit(line_bit), .frame_start(frame_start), .a_ext(a_ext), .n_ext(n_ext),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct { logic lb; logic fs; logic pr; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;

  localparam logic [9:0] WORD = 10'b1111010000;
  int m_pos;
  logic s_a, s_n, x_a, x_n, m_ea, m_en;
  logic [1:0] s_as, s_ns, x_as, x_ns;
  logic [9:0] s_m, x_m;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = 0; s_a = 1; s_n = 0; s_as = 0; s_ns = 0; s_m = 0;
    x_a = 1; x_n = 0; x_as = 0; x_ns = 0; x_m = 0; m_ea = 0; m_en = 0;
    q.delete();
  endtask

  // driver: predicts the emitted bit and queues it
  task automatic step(input bit c, input bit w = 0, input logic [1:0] wa = 0,
                      input logic [7:0] wd = 0);
    exp_t e;
    ce = c; wr_en = w; wr_addr = wa; wr_data = wd;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pay_data = lfsr[0];
    if (c) begin
      e.fs = (m_pos == 0);
      if (m_pos == 0) begin m_ea = a_ext; m_en = n_ext; end
      if (m_pos < 10) begin
        e.lb  = WORD[9 - m_pos] ^ x_m[9 - m_pos];
        e.tag = (s_m != x_m) ? "R6" : ((x_m == 0) ? "R1" : "R5");
      end else if (m_pos == 10) begin
        e.lb = (x_as == 0) ? x_a : m_ea; e.tag = (x_as == 0) ? "R3" : "R4";
      end else if (m_pos == 11) begin
        e.lb = (x_ns == 0) ? x_n : m_en; e.tag = (x_ns == 0) ? "R3" : "R4";
      end else begin
        e.lb = pay_data; e.tag = "R2";
      end
      if (m_pos == FB - 1) begin
        x_a = s_a; x_n = s_n; x_as = s_as; x_ns = s_ns; x_m = s_m;
      end
      m_pos = (m_pos + 1) % FB;
      e.pr = (m_pos >= 12);
      q.push_back(e);
    end
    if (w) begin
      case (wa)
        2'd0: begin s_a = wd[1]; s_n = wd[0]; end
        2'd1: begin s_as = wd[1:0]; s_ns = wd[3:2]; end
        2'd2: s_m[9:5] = wd[4:0];
        default: s_m[4:0] = wd[4:0];
      endcase
    end
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1);
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    step(0);
    chk(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    ce = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    chk("R10 line_bit", {7'b0, line_bit}, 8'h0);
    chk("R10 frame_start", {7'b0, frame_start}, 8'h0);
    chk("R10 pay_req", {7'b0, pay_req}, 8'h0);
  endtask

  // monitor: pops predictions on enabled edges, checks hold otherwise
  initial begin
    logic plb, pfs, ppr;
    exp_t e;
    plb = 0; pfs = 0; ppr = 0;
    forever begin
      @(posedge clk);
      if (rst) begin
        #1; plb = line_bit; pfs = frame_start; ppr = pay_req;
      end else if (ce) begin
        #1;
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2 actual=output expected=nothing queued");
        end else begin
          e = q.pop_front();
          chk({e.tag, " line_bit"}, {7'b0, line_bit}, {7'b0, e.lb});
          chk("R7 frame_start", {7'b0, frame_start}, {7'b0, e.fs});
          chk("R8 pay_req", {7'b0, pay_req}, {7'b0, e.pr});
        end
        plb = line_bit; pfs = frame_start; ppr = pay_req;
      end else begin
        #1;
        chk("R9 hold", {5'b0, line_bit, frame_start, pay_req}, {5'b0, plb, pfs, ppr});
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();
    rdchk(ADDR_SVC, 8'h02, "R10 svc default");
    rdchk(ADDR_SRC, 8'h00, "R10 src default");
    rdchk(ADDR_MHI, 8'h00, "R10 mhi default");
    rdchk(ADDR_MLO, 8'h00, "R10 mlo default");
    run(2 * FB);                                   // R1 R2 R3 defaults
    for (int i = 0; i < 3 * FB; i++) step(i % 3 == 0); // R9 sparse enables
    run(20);
    step(1, 1, ADDR_MHI, 8'h15);                   // R5 R6 mid-frame masks
    step(1, 1, ADDR_MLO, 8'h03);
    run(2 * FB);
    step(0, 1, ADDR_SVC, 8'h01);                   // R3 A=0 N=1
    run(FB + 5);
    a_ext = 1; n_ext = 0;
    step(1, 1, ADDR_SRC, 8'h01);                   // R4 A from pin
    run(FB);
    while (m_pos != 5) step(1);
    a_ext = 0; n_ext = 1;                          // R4 change after sampling
    run(FB + 2);
    step(1, 1, ADDR_SRC, 8'h0E);                   // R4 both from pins
    run(FB);
    while (m_pos != 3) step(1);
    n_ext = 0;
    run(FB);
    while (m_pos != FB - 1) step(1);
    step(1, 1, ADDR_MHI, 8'h1F);                   // R6 write on boundary
    run(2 * FB);
    run(17);
    do_reset();                                    // R10 mid-frame reset
    rdchk(ADDR_MHI, 8'h00, "R10 mhi after reset");
    run(FB + 3);
    step(0, 1, ADDR_MLO, 8'hFA);
    rdchk(ADDR_MLO, 8'h1A, "R10 readback");
    step(0, 1, ADDR_SRC, 8'hF7);
    rdchk(ADDR_SRC, 8'h07, "R10 src readback");
    run(2 * FB);
    finish_run();
  end
endmodule